// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the register front end of a sixteen-channel DMA engine. A host writes and reads word-aligned offsets. Behind each offset is either a per-channel setting or a shared word. The per-channel settings are buffer address, line length, line count, a six-bit control word and the line pitch. The shared words are stop, interrupt status, interrupt enable and loop control. Interrupt enable and loop control each also have a clear alias.

The channel engines report the end of a transfer with a one-cycle done pulse per channel. The bank latches that pulse as a pending bit and drives a single combined interrupt line. In the other direction, the bank gives the engines their configuration as flat vectors. It also sends one-cycle start and stop strobes, plus a per-channel loop enable. A channel loops only while both of its loop-control bits are set: bit `ch` and bit `ch+16`.

Writes take effect at the clock edge on which `wrEn` is high. Reads are combinational from the current `addr`.

Top module: `dmaRegBank`

## Requirements
- R1: After reset every stored register reads zero, and `irqOut`, `startPulse`, `stopPulse` and `loopEn` are low.
- R2: Each channel `ch` has a 16-byte window at `ch*0x10`, laid out as follows:
  - 0x0 is the buffer address;
  - 0x4 is the line length;
  - 0x8 is the line count;
  - 0xC is the control word, which keeps only bits [5:0] and reads zero above them.
  Each register reads back the written value and appears on the matching flat output slice `[ch*32 +: 32]`.
- R3: In the control word, bits [3:0] hold a channel number (readable only). Bit 4 selects bursts of four words and drives `chBurst4[ch]`. Bit 5 set means memory-to-device and drives `chToDev[ch]`.
- R4: The line pitch for channel `ch`, counted in 32-bit words, is at `0x100 + 4*ch`. It reads back and drives `chPitch[ch*32 +: 32]`.
- R5: The interrupt status word at 0x144 has bit `ch` per channel, set by `doneIn[ch]` whatever the enable. Writing a 1 to a bit clears only that bit. A done pulse in the same cycle as a clear of that bit leaves it set.
- R6: Interrupt enable at 0x148 takes the written bits. A write to 0x14C clears the bits written as 1 and leaves the others alone. 0x14C reads zero.
- R7: `irqOut` is high exactly when some channel has both its status bit and its enable bit set. It follows register state in the cycle after the edge that changed it.
- R8: Loop control at 0x150 stores bits `ch` and `ch+16` for existing channels. A write to 0x15C clears the bits written as 1. `loopEn[ch]` is high only while both bit `ch` and bit `ch+16` are set.
- R9: Writing to 0x140 raises `stopPulse[ch]` for exactly the cycle after the write, for each bit `ch` written as 1. 0x140 reads zero.
- R10: A write to a channel's address register (+0x0) raises `startPulse[ch]` for exactly the cycle after the write.
- R11: Unmapped offsets read zero and ignore writes. These are 0x154, 0x158, anything above 0x15C, and any address whose two low bits are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for `addr`/`wrData` |
| addr | input | ADDR_W | Byte offset of the access |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr`, combinational |
| doneIn | input | NUM_CH | Per-channel transfer-done pulses |
| irqOut | output | 1 | Combined interrupt |
| startPulse | output | NUM_CH | One-cycle start strobes |
| stopPulse | output | NUM_CH | One-cycle stop strobes |
| loopEn | output | NUM_CH | Per-channel loop enable |
| chAddr | output | NUM_CH*DATA_W | Buffer addresses, flat |
| chLineLen | output | NUM_CH*DATA_W | Line lengths, flat |
| chLineCnt | output | NUM_CH*DATA_W | Line counts, flat |
| chPitch | output | NUM_CH*DATA_W | Line pitches, flat |
| chBurst4 | output | NUM_CH | Four-word burst select |
| chToDev | output | NUM_CH | Direction, 1 = memory to device |

## Verification
A wrong channel index in the decoder lands a write in a neighbour's window. The flat configuration outputs show this on the very next cycle, before any readback. A status or enable bit held in the wrong state shows on `irqOut` one cycle after the offending done pulse or write. Loop bits show on `loopEn` one cycle after the write. A strobe that is missing or lasts too long shows in the cycle after the write, because the strobes are compared against their expected values on every clock.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;
  localparam int CH_IDX_W = 4;
  localparam int MAX_CH   = 16;
  localparam int LOOP_HI  = 16;

  localparam logic [8:0] OFF_PITCH   = 9'h100;
  localparam logic [8:0] OFF_STOP    = 9'h140;
  localparam logic [8:0] OFF_STAT    = 9'h144;
  localparam logic [8:0] OFF_IEN     = 9'h148;
  localparam logic [8:0] OFF_IENCLR  = 9'h14C;
  localparam logic [8:0] OFF_LOOP    = 9'h150;
  localparam logic [8:0] OFF_LOOPCLR = 9'h15C;

  typedef enum logic [3:0] {
    REG_NONE, REG_ADDR, REG_LLEN, REG_LCNT, REG_CTRL, REG_PITCH,
    REG_STOP, REG_STAT, REG_IEN, REG_IENCLR, REG_LOOP, REG_LOOPCLR
  } regKind_e;

  typedef struct packed {
    logic                wr;
    regKind_e            kind;
    logic [CH_IDX_W-1:0] ch;
  } regStrobe_t;
endpackage

// File: rtl/dmaRegDecode.sv
module dmaRegDecode
  import dmaRegPkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 9
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strb
);
  always_comb begin
    strb.kind = REG_NONE;
    strb.ch   = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr < ADDR_W'(OFF_PITCH)) begin
        if (int'(addr[7:4]) < NUM_CH) begin
          strb.ch = addr[7:4];
          case (addr[3:2])
            2'd0:    strb.kind = REG_ADDR;
            2'd1:    strb.kind = REG_LLEN;
            2'd2:    strb.kind = REG_LCNT;
            default: strb.kind = REG_CTRL;
          endcase
        end
      end else if (addr < ADDR_W'(OFF_STOP)) begin
        if (int'(addr[5:2]) < NUM_CH) begin
          strb.ch   = addr[5:2];
          strb.kind = REG_PITCH;
        end
      end else begin
        if      (addr == ADDR_W'(OFF_STOP))    strb.kind = REG_STOP;
        else if (addr == ADDR_W'(OFF_STAT))    strb.kind = REG_STAT;
        else if (addr == ADDR_W'(OFF_IEN))     strb.kind = REG_IEN;
        else if (addr == ADDR_W'(OFF_IENCLR))  strb.kind = REG_IENCLR;
        else if (addr == ADDR_W'(OFF_LOOP))    strb.kind = REG_LOOP;
        else if (addr == ADDR_W'(OFF_LOOPCLR)) strb.kind = REG_LOOPCLR;
      end
    end
    strb.wr = wrEn && (strb.kind != REG_NONE);
  end
endmodule

// File: rtl/dmaRegFile.sv
module dmaRegFile
  import dmaRegPkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  regStrobe_t               strb,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [NUM_CH-1:0]        doneIn,
  output logic [DATA_W-1:0]        rdData,
  output logic                     irqOut,
  output logic [NUM_CH-1:0]        startPulse,
  output logic [NUM_CH-1:0]        stopPulse,
  output logic [NUM_CH-1:0]        loopEn,
  output logic [NUM_CH*DATA_W-1:0] chAddr,
  output logic [NUM_CH*DATA_W-1:0] chLineLen,
  output logic [NUM_CH*DATA_W-1:0] chLineCnt,
  output logic [NUM_CH*DATA_W-1:0] chPitch,
  output logic [NUM_CH-1:0]        chBurst4,
  output logic [NUM_CH-1:0]        chToDev
);
  localparam int CTRL_W = 6;
  localparam logic [DATA_W-1:0] CH_MASK   = DATA_W'((64'd1 << NUM_CH) - 64'd1);
  localparam logic [DATA_W-1:0] LOOP_MASK = CH_MASK | (CH_MASK << LOOP_HI);

  logic [NUM_CH*CTRL_W-1:0] ctrlFlat;
  logic [NUM_CH-1:0]        statQ, ienQ, wMask, statClr;
  logic [DATA_W-1:0]        loopQ;
  int                       rdIdx;

  assign wMask   = wrData[NUM_CH-1:0];
  assign statClr = (strb.wr && strb.kind == REG_STAT) ? wMask : '0;
  assign rdIdx   = int'(strb.ch);

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic              hit;
    logic [DATA_W-1:0] addrR, llenR, lcntR, pitchR;
    logic [CTRL_W-1:0] ctrlR;
    assign hit = strb.wr && (strb.ch == CH_IDX_W'(c));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrR  <= '0;
        llenR  <= '0;
        lcntR  <= '0;
        pitchR <= '0;
        ctrlR  <= '0;
      end else if (hit) begin
        case (strb.kind)
          REG_ADDR:  addrR  <= wrData;
          REG_LLEN:  llenR  <= wrData;
          REG_LCNT:  lcntR  <= wrData;
          REG_PITCH: pitchR <= wrData;
          REG_CTRL:  ctrlR  <= wrData[CTRL_W-1:0];
          default: ;
        endcase
      end
    end
    assign chAddr   [c*DATA_W +: DATA_W] = addrR;
    assign chLineLen[c*DATA_W +: DATA_W] = llenR;
    assign chLineCnt[c*DATA_W +: DATA_W] = lcntR;
    assign chPitch  [c*DATA_W +: DATA_W] = pitchR;
    assign ctrlFlat [c*CTRL_W +: CTRL_W] = ctrlR;
    assign chBurst4[c] = ctrlR[4];
    assign chToDev[c]  = ctrlR[5];
    assign loopEn[c]   = loopQ[c] & loopQ[c+LOOP_HI];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ      <= '0;
      ienQ       <= '0;
      loopQ      <= '0;
      startPulse <= '0;
      stopPulse  <= '0;
    end else begin
      statQ <= (statQ & ~statClr) | doneIn;
      for (int c = 0; c < NUM_CH; c++)
        startPulse[c] <= strb.wr && strb.kind == REG_ADDR && strb.ch == CH_IDX_W'(c);
      stopPulse <= (strb.wr && strb.kind == REG_STOP) ? wMask : '0;
      if (strb.wr) begin
        case (strb.kind)
          REG_IEN:     ienQ  <= wMask;
          REG_IENCLR:  ienQ  <= ienQ & ~wMask;
          REG_LOOP:    loopQ <= wrData & LOOP_MASK;
          REG_LOOPCLR: loopQ <= loopQ & ~wrData;
          default: ;
        endcase
      end
    end
  end

  assign irqOut = |(statQ & ienQ);

  always_comb begin
    rdData = '0;
    case (strb.kind)
      REG_ADDR:  rdData = chAddr   [rdIdx*DATA_W +: DATA_W];
      REG_LLEN:  rdData = chLineLen[rdIdx*DATA_W +: DATA_W];
      REG_LCNT:  rdData = chLineCnt[rdIdx*DATA_W +: DATA_W];
      REG_PITCH: rdData = chPitch  [rdIdx*DATA_W +: DATA_W];
      REG_CTRL:  rdData = DATA_W'(ctrlFlat[rdIdx*CTRL_W +: CTRL_W]);
      REG_STAT:  rdData = DATA_W'(statQ);
      REG_IEN:   rdData = DATA_W'(ienQ);
      REG_LOOP:  rdData = loopQ;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/dmaRegBank.sv
module dmaRegBank
  import dmaRegPkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  input  logic [NUM_CH-1:0]        doneIn,
  output logic                     irqOut,
  output logic [NUM_CH-1:0]        startPulse,
  output logic [NUM_CH-1:0]        stopPulse,
  output logic [NUM_CH-1:0]        loopEn,
  output logic [NUM_CH*DATA_W-1:0] chAddr,
  output logic [NUM_CH*DATA_W-1:0] chLineLen,
  output logic [NUM_CH*DATA_W-1:0] chLineCnt,
  output logic [NUM_CH*DATA_W-1:0] chPitch,
  output logic [NUM_CH-1:0]        chBurst4,
  output logic [NUM_CH-1:0]        chToDev
);
  regStrobe_t strb;

  dmaRegDecode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uDecode (
    .wrEn(wrEn), .addr(addr), .strb(strb)
  );

  dmaRegFile #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uFile (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .doneIn(doneIn),
    .rdData(rdData), .irqOut(irqOut), .startPulse(startPulse),
    .stopPulse(stopPulse), .loopEn(loopEn), .chAddr(chAddr),
    .chLineLen(chLineLen), .chLineCnt(chLineCnt), .chPitch(chPitch),
    .chBurst4(chBurst4), .chToDev(chToDev)
  );
endmodule

// File: rtl/dmaRegBankChk.sv
module dmaRegBankChk #(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [ADDR_W-1:0]        addr,
  input logic [NUM_CH-1:0]        doneIn,
  input logic                     irqOut,
  input logic [NUM_CH-1:0]        startPulse,
  input logic [NUM_CH-1:0]        stopPulse,
  input logic [NUM_CH-1:0]        loopEn,
  input logic [NUM_CH*DATA_W-1:0] chAddr,
  input logic [NUM_CH*DATA_W-1:0] chPitch
);
  // R10
  start_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse != '0) |-> $past(wrEn) && ($past(addr) < ADDR_W'(9'h100)) && ($past(addr[3:0]) == 4'h0));

  // R10
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(startPulse));

  // R9
  stop_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopPulse != '0) |-> $past(wrEn) && ($past(addr) == ADDR_W'(9'h140)));

  // R8
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(loopEn) |-> $past(wrEn));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(wrEn || (doneIn != '0)));

  // R11
  unmapped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == ADDR_W'(9'h154) || addr == ADDR_W'(9'h158))) |=>
      $stable(loopEn) && $stable(chAddr) && $stable(chPitch) &&
      (startPulse == '0) && (stopPulse == '0));
endmodule

bind dmaRegBank dmaRegBankChk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .doneIn(doneIn),
  .irqOut(irqOut), .startPulse(startPulse), .stopPulse(stopPulse),
  .loopEn(loopEn), .chAddr(chAddr), .chPitch(chPitch)
);

// File: tb/tb_dmaRegBank.sv
module tb_dmaRegBank;
  localparam int NCH = 16;
  localparam int DW  = 32;
  localparam int AW  = 9;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0, rdData;
  logic [NCH-1:0] doneIn = '0, startPulse, stopPulse, loopEn, chBurst4, chToDev;
  logic irqOut;
  logic [NCH*DW-1:0] chAddr, chLineLen, chLineCnt, chPitch;

  always #5 clk = ~clk;

  dmaRegBank #(.NUM_CH(NCH), .DATA_W(DW), .ADDR_W(AW)) dut (.*);

  int nVec = 0, nBad = 0;

  // behavioural reference state
  logic [31:0] mAddr [NCH], mLlen [NCH], mLcnt [NCH], mPitch [NCH];
  logic [5:0]  mCtrl [NCH];
  logic [15:0] mStat = '0, mIen = '0, mStart = '0, mStop = '0;
  logic [31:0] mLoop = '0;

  task automatic chk(input string tag, input string what, input logic [NCH*DW-1:0] act, input logic [NCH*DW-1:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input int a);
    if (a % 4 != 0) return 0;
    if (a < 256) begin
      case (a % 16)
        0: return mAddr[a/16];
        4: return mLlen[a/16];
        8: return mLcnt[a/16];
        default: return {26'd0, mCtrl[a/16]};
      endcase
    end
    if (a < 320) return mPitch[(a-256)/4];
    if (a == 324) return {16'd0, mStat};
    if (a == 328) return {16'd0, mIen};
    if (a == 336) return mLoop;
    return 0;
  endfunction

  function automatic string tagOf(input int a);
    if (a % 4 != 0) return "R11";
    if (a < 256) return (a % 16 == 12) ? "R3" : "R2";
    if (a < 320) return "R4";
    case (a)
      320: return "R9";
      324: return "R5";
      328, 332: return "R6";
      336, 348: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic modelEdge();
    int a = int'(addr);
    logic [15:0] clr = '0;
    mStart = '0;
    mStop  = '0;
    if (wrEn && a % 4 == 0) begin
      if (a < 256) begin
        case (a % 16)
          0: begin mAddr[a/16] = wrData; mStart[a/16] = 1'b1; end
          4: mLlen[a/16] = wrData;
          8: mLcnt[a/16] = wrData;
          default: mCtrl[a/16] = wrData[5:0];
        endcase
      end else if (a < 320) mPitch[(a-256)/4] = wrData;
      else case (a)
        320: mStop = wrData[15:0];
        324: clr = wrData[15:0];
        328: mIen = wrData[15:0];
        332: mIen = mIen & ~wrData[15:0];
        336: mLoop = wrData;
        348: mLoop = mLoop & ~wrData;
        default: ;
      endcase
    end
    mStat = (mStat & ~clr) | doneIn;
  endtask

  task automatic compareAll(input bit atReset);
    logic [NCH*DW-1:0] eA, eL, eC, eP;
    logic [NCH-1:0] eLoop, eB, eD;
    for (int c = 0; c < NCH; c++) begin
      eA[c*DW +: DW] = mAddr[c];
      eL[c*DW +: DW] = mLlen[c];
      eC[c*DW +: DW] = mLcnt[c];
      eP[c*DW +: DW] = mPitch[c];
      eLoop[c] = mLoop[c] & mLoop[c+16];
      eB[c] = mCtrl[c][4];
      eD[c] = mCtrl[c][5];
    end
    chk(atReset ? "R1" : tagOf(int'(addr)), "rdData", rdData, expRead(int'(addr)));
    chk(atReset ? "R1" : "R7", "irqOut", irqOut, |(mStat & mIen));
    chk(atReset ? "R1" : "R10", "startPulse", startPulse, mStart);
    chk(atReset ? "R1" : "R9", "stopPulse", stopPulse, mStop);
    chk(atReset ? "R1" : "R8", "loopEn", loopEn, eLoop);
    chk(atReset ? "R1" : "R2", "chAddr", chAddr, eA);
    chk(atReset ? "R1" : "R2", "chLineLen", chLineLen, eL);
    chk(atReset ? "R1" : "R2", "chLineCnt", chLineCnt, eC);
    chk(atReset ? "R1" : "R4", "chPitch", chPitch, eP);
    chk(atReset ? "R1" : "R3", "chBurst4", chBurst4, eB);
    chk(atReset ? "R1" : "R3", "chToDev", chToDev, eD);
  endtask

  task automatic step(input logic we, input int a, input logic [31:0] d, input logic [15:0] dn);
    wrEn = we; addr = AW'(a); wrData = d; doneIn = dn;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll(1'b0);
  endtask

  task automatic rd(input int a);
    step(1'b0, a, 32'h0, 16'h0);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    step(1'b1, a, d, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    int pick [14] = '{0, 4, 8, 12, 256, 320, 324, 328, 332, 336, 348, 340, 344, 350};
    for (int c = 0; c < NCH; c++) begin
      mAddr[c] = '0; mLlen[c] = '0; mLcnt[c] = '0; mPitch[c] = '0; mCtrl[c] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    compareAll(1'b1);

    // R2 R10 per-channel windows
    for (int c = 0; c < NCH; c++) begin
      wr(c*16 + 0, 32'h1000_0000 + c*32'h0101);
      wr(c*16 + 4, 32'h0000_0040 + c);
      wr(c*16 + 8, 32'h0000_0100 ^ c);
      wr(c*16 + 12, 32'hFFFF_FFC0 | c);
    end
    for (int c = 0; c < NCH; c++) begin
      rd(c*16 + 0); rd(c*16 + 4); rd(c*16 + 8); rd(c*16 + 12);
    end
    // R3 control fields: keep [5:0], burst and direction
    wr(3*16 + 12, 32'hFFFF_FFFF); rd(3*16 + 12);
    wr(7*16 + 12, 32'h0000_0017); rd(7*16 + 12);
    wr(9*16 + 12, 32'h0000_0029); rd(9*16 + 12);
    // R4 pitch
    for (int c = 0; c < NCH; c++) wr(256 + 4*c, 32'h0000_0200 + c);
    for (int c = 0; c < NCH; c++) rd(256 + 4*c);

    // R5 status set by done even with enable low
    step(1'b0, 324, 0, 16'h0024);
    rd(324);
    wr(324, 32'h0000_0004);           // R5 clear only bit 2
    rd(324);
    step(1'b1, 324, 32'h20, 16'h0020); // R5 set wins over clear
    rd(324);
    // R6 R7 enable and combined interrupt
    wr(328, 32'h0000_0024);
    rd(328);
    wr(332, 32'h0000_0020);
    rd(332);
    rd(328);
    step(1'b0, 328, 0, 16'h0004);
    wr(324, 32'h0000_FFFF);
    rd(324);

    // R8 loop control
    wr(336, 32'h0003_0003);
    rd(336);
    wr(336, 32'h0004_0000);
    wr(336, 32'h0007_0005);
    wr(348, 32'h0001_0000);
    rd(336);
    // R11 unmapped writes ignored
    wr(340, 32'hFFFF_FFFF);
    wr(344, 32'hFFFF_FFFF);
    rd(340); rd(344); rd(336);
    wr(352, 32'hFFFF_FFFF); rd(352);
    wr(508, 32'hFFFF_FFFF); rd(508);
    wr(258, 32'hDEAD_BEEF); rd(258); rd(256);
    wr(1, 32'hDEAD_BEEF); rd(1); rd(0);

    // R9 stop strobes, one cycle
    wr(320, 32'h0000_8001);
    rd(320);
    rd(320);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int a;
      logic [31:0] d;
      seed = seed * 32'd1664525 + 32'd1013904223;
      a = pick[(seed >> 8) % 14];
      if (a < 256) a = a + 16 * ((seed >> 16) % NCH);
      if (a == 256) a = a + 4 * ((seed >> 20) % NCH);
      d = seed ^ (seed << 7);
      step(seed[3], a, d, seed[31] ? 16'(1 << ((seed >> 24) % NCH)) : 16'h0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule